// File: doc/BRIEF.md
# Low-Window Register Shadow Decoder

This block sits between a host's asynchronous, SRAM-style byte bus and an attached static RAM. It decodes a 17-bit byte address. The lowest 64 locations are served from an on-chip register file, and every higher location goes to the external RAM. Software therefore sees one continuous memory map. The first 14 on-chip bytes are set aside for clock functions and the other 50 are general storage. In this block all 64 are modelled as plain read/write bytes.

The host control strobes are active-low: chip enable, output enable and write enable. They are brought into a system clock domain through two-flop synchronizers. The address and write data are delayed by the same number of stages, so they stay aligned with the strobes. A five-state controller tracks the access in progress:

- `ST_IDLE` is the state with no access in progress.
- `ST_RD_LOCAL` is a read inside the window. `ST_RD_REMOTE` is a read above it.
- `ST_WR_LOCAL` is a write inside the window. `ST_WR_REMOTE` is a write above it.

The controller moves between these states as follows:

- From `ST_IDLE` it goes to a write state when the write term (chip enable AND write enable, both low) is seen. The window decides which write state.
- Otherwise, from `ST_IDLE` it goes to a read state when chip enable and output enable are low and write enable is high.
- A read state swaps to the other read state when the address crosses the window edge.
- Every state returns to `ST_IDLE` when its term drops.
- Leaving `ST_WR_LOCAL` commits the held write data to the register file.

The byte bus is split into an input `wr_data`, an output `rd_data` and a drive enable `rd_drive`. Together they form the tri-state data pin at the chip edge. The external RAM output enable `ram_oe_n` is the host output enable passed through for out-of-window accesses. It is held high for in-window accesses and during reset.

Top module: `regwin_top`

## Requirements
- R1: Addresses 0x00000 to 0x0003F (0 to 63) select the on-chip window. Addresses 0x00040 to 0x1FFFF select the external RAM. The boundary bytes 0x3F and 0x40 fall on the two sides.
- R2: A read needs we_n=1, ce_n=0 and oe_n=0. When the address is below 0x40 and the strobes have been held for at least 4 clock cycles, rd_drive=1 and rd_data equals the addressed register.
- R3: While the address is below 0x40, ram_oe_n stays 1 for the whole access, and never falls while rd_drive=1.
- R4: When ce_n=0 and the address is 0x40 or above (outside reset), ram_oe_n equals oe_n combinationally. ram_oe_n is never 0 while oe_n=1.
- R5: rd_drive is 0 and rd_data is 0 whenever oe_n=1, we_n=0, ce_n=1, or the address is 0x40 or above.
- R6: A write to a register below 0x40 is active while ce_n=0 and we_n=0. It commits within 5 clock cycles after the term ends. This holds whether we_n rises first (write-enable controlled) or ce_n rises first (chip-enable controlled).
- R7: The committed byte is the wr_data value present at the end of the write term. Earlier values during the term, and values presented after the term ends, are not stored.
- R8: A write at 0x40 or above leaves every on-chip register unchanged.
- R9: Synchronous active-high reset clears all 64 registers to 0, holds ram_oe_n=1 while asserted, and returns the controller to ST_IDLE with rd_drive=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the host strobes |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 17 | Host byte address |
| ce_n | input | 1 | Host chip enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| we_n | input | 1 | Host write enable, active low |
| wr_data | input | 8 | Byte from the host data pins |
| rd_data | output | 8 | Byte driven to the host data pins (0 when not driving) |
| rd_drive | output | 1 | Drive enable of the data pins (tri-state control) |
| ram_oe_n | output | 1 | Output enable to the external RAM, active low |

## Verification
The checker verifies the following on every cycle:

- ram_oe_n stays high for in-window addresses (R3).
- ram_oe_n never asserts without the host output enable (R4).
- The block never drives the data pins while the external RAM is enabled (R3, R5).
- rd_drive is clear right after reset (R9).

Only the bench's scenarios can show the rest:

- Register contents round-trip through writes and reads.
- The last-value capture at the end of a write term, for both terminating strobes.
- That writes above the window leave the registers untouched.
- That reset clears all 64 bytes.

These behaviours depend on sequences of stored state.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RD_LOCAL  = 3'd1,
        ST_RD_REMOTE = 3'd2,
        ST_WR_LOCAL  = 3'd3,
        ST_WR_REMOTE = 3'd4
    } win_state_t;

endpackage

// File: rtl/regwin_sync.sv
// Multi-stage sampling chain. Used as a synchronizer for strobes and as a
// matching delay line for address and data so all stay aligned.
module regwin_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[gi] <= RST_VAL;
                    else     stg[gi] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[gi] <= RST_VAL;
                    else     stg[gi] <= stg[gi-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/regwin_regfile.sv
// On-chip byte window: one synchronous write port, one combinational read port.
module regwin_regfile #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_byte
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_byte;
        end
    end

    assign rd_byte = mem[rd_idx];

endmodule

// File: rtl/regwin_fsm.sv
// Access tracker working on the synchronized strobes and aligned address/data.
module regwin_fsm
    import regwin_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int WIN_DEPTH = 64,
    localparam int IDX_W    = $clog2(WIN_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_s_n,
    input  logic              oe_s_n,
    input  logic              we_s_n,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    output win_state_t        state,
    output logic              commit_en,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [DATA_W-1:0] commit_byte
);

    win_state_t state_nx;
    logic       wr_term;
    logic       rd_term;
    logic       in_win_s;

    logic [ADDR_W-1:0] addr_hold;
    logic [DATA_W-1:0] data_hold;

    assign wr_term  = !ce_s_n && !we_s_n;
    assign rd_term  = !ce_s_n && !oe_s_n && we_s_n;
    assign in_win_s = (addr_s < ADDR_W'(WIN_DEPTH));

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_term)      state_nx = in_win_s ? ST_WR_LOCAL : ST_WR_REMOTE;
                else if (rd_term) state_nx = in_win_s ? ST_RD_LOCAL : ST_RD_REMOTE;
            end
            ST_RD_LOCAL: begin
                if (!rd_term)      state_nx = ST_IDLE;
                else if (!in_win_s) state_nx = ST_RD_REMOTE;
            end
            ST_RD_REMOTE: begin
                if (!rd_term)     state_nx = ST_IDLE;
                else if (in_win_s) state_nx = ST_RD_LOCAL;
            end
            ST_WR_LOCAL: begin
                if (!wr_term) state_nx = ST_IDLE;
            end
            ST_WR_REMOTE: begin
                if (!wr_term) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // Hold the last address/data seen while the write term is active
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_hold <= '0;
            data_hold <= '0;
        end else if (wr_term) begin
            addr_hold <= addr_s;
            data_hold <= data_s;
        end
    end

    // Outputs
    always_comb begin
        commit_en = 1'b0;
        unique case (state)
            ST_WR_LOCAL: commit_en = !wr_term;
            ST_IDLE, ST_RD_LOCAL, ST_RD_REMOTE, ST_WR_REMOTE: commit_en = 1'b0;
            default: commit_en = 1'b0;
        endcase
    end

    assign commit_idx  = addr_hold[IDX_W-1:0];
    assign commit_byte = data_hold;

endmodule

// File: rtl/regwin_top.sv
module regwin_top
    import regwin_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 8,
    parameter int WIN_DEPTH   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive,
    output logic              ram_oe_n
);

    localparam int IDX_W = $clog2(WIN_DEPTH);
    localparam int PIPE_W = ADDR_W + DATA_W;

    logic [2:0]        ctl_s;
    logic [PIPE_W-1:0] pipe_s;
    win_state_t        state;
    logic              commit_en;
    logic [IDX_W-1:0]  commit_idx;
    logic [DATA_W-1:0] commit_byte;
    logic [DATA_W-1:0] rf_q;
    logic              in_win;

    regwin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_ctl_sync (
        .clk (clk),
        .rst (rst),
        .din ({ce_n, oe_n, we_n}),
        .dout(ctl_s)
    );

    regwin_sync #(.W(PIPE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_pipe (
        .clk (clk),
        .rst (rst),
        .din ({addr, wr_data}),
        .dout(pipe_s)
    );

    regwin_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_DEPTH(WIN_DEPTH)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ce_s_n     (ctl_s[2]),
        .oe_s_n     (ctl_s[1]),
        .we_s_n     (ctl_s[0]),
        .addr_s     (pipe_s[PIPE_W-1:DATA_W]),
        .data_s     (pipe_s[DATA_W-1:0]),
        .state      (state),
        .commit_en  (commit_en),
        .commit_idx (commit_idx),
        .commit_byte(commit_byte)
    );

    regwin_regfile #(.DEPTH(WIN_DEPTH), .DATA_W(DATA_W)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (commit_en),
        .wr_idx (commit_idx),
        .wr_byte(commit_byte),
        .rd_idx (addr[IDX_W-1:0]),
        .rd_byte(rf_q)
    );

    assign in_win = (addr < ADDR_W'(WIN_DEPTH));

    // Pin-side outputs: the state grants the drive, live strobes gate it
    always_comb begin
        rd_drive = 1'b0;
        unique case (state)
            ST_RD_LOCAL: rd_drive = !rst && in_win && !ce_n && !oe_n && we_n;
            ST_IDLE, ST_RD_REMOTE, ST_WR_LOCAL, ST_WR_REMOTE: rd_drive = 1'b0;
            default: rd_drive = 1'b0;
        endcase
    end

    assign rd_data  = rd_drive ? rf_q : '0;
    assign ram_oe_n = rst || in_win || ce_n || oe_n;

endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
    parameter int ADDR_W    = 17,
    parameter int WIN_DEPTH = 64
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              oe_n,
    input logic              rd_drive,
    input logic              ram_oe_n
);

    // R3
    local_oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (addr < ADDR_W'(WIN_DEPTH)) |-> ram_oe_n);

    // R4
    no_oe_without_host_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> ram_oe_n);

    // R5
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        rd_drive |-> ram_oe_n);

    // R9
    drive_off_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rd_drive);

    // R9
    always_comb begin
        if (rst) begin
            rst_oe_chk: assert (ram_oe_n);
        end
    end

endmodule

bind regwin_top regwin_chk #(.ADDR_W(ADDR_W), .WIN_DEPTH(WIN_DEPTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .oe_n    (oe_n),
    .rd_drive(rd_drive),
    .ram_oe_n(ram_oe_n)
);

// File: tb/tb_regwin_top.sv
module tb_regwin_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int NWIN = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_drive;
    logic          ram_oe_n;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [DW-1:0] model [NWIN];

    always #(CLK_PERIOD/2) clk = ~clk;

    regwin_top dut (
        .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .wr_data(wr_data), .rd_data(rd_data),
        .rd_drive(rd_drive), .ram_oe_n(ram_oe_n)
    );

    function automatic bit in_window(input logic [AW-1:0] a);
        return a < AW'(NWIN);
    endfunction

    function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
        return in_window(a) ? model[a[5:0]] : '0;
    endfunction

    function automatic logic exp_ram_oe(input logic [AW-1:0] a, input logic c, input logic o);
        return in_window(a) || c || o;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Write: first byte for 3 cycles, last byte for 3 cycles, then release.
    // by_ce selects which strobe terminates the term.
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d_first,
                            input logic [DW-1:0] d_last, input bit by_ce);
        @(negedge clk);
        addr = a; oe_n = 1'b1; wr_data = d_first;
        if (by_ce) begin we_n = 1'b0; @(negedge clk); ce_n = 1'b0; end
        else       begin ce_n = 1'b0; @(negedge clk); we_n = 1'b0; end
        idle(3);
        wr_data = d_last;
        idle(3);
        if (by_ce) ce_n = 1'b1; else we_n = 1'b1;
        wr_data = ~d_last;
        idle(1);
        we_n = 1'b1; ce_n = 1'b1;
        idle(5);
        if (in_window(a)) model[a[5:0]] = d_last;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                           output logic drv, output logic oe_bad);
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        oe_bad = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (ram_oe_n !== exp_ram_oe(a, 1'b0, 1'b0)) oe_bad = 1'b1;
        end
        d = rd_data; drv = rd_drive;
        ce_n = 1'b1; oe_n = 1'b1;
        idle(4);
    endtask

    task automatic read_check(input string req, input logic [AW-1:0] a);
        logic [DW-1:0] d; logic drv; logic ob;
        do_read(a, d, drv, ob);
        check(req, {31'd0, drv}, {31'd0, in_window(a)});
        check(req, {24'd0, d}, {24'd0, exp_rd(a)});
        check("R3/R4 ram_oe_n", {31'd0, ob}, 32'd0);
    endtask

    initial begin
        logic [DW-1:0] d; logic drv; logic ob;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < NWIN; i++) model[i] = '0;

        // R9: reset state
        idle(3);
        check("R9 rd_drive in reset", {31'd0, rd_drive}, 32'd0);
        addr = 17'h100; ce_n = 1'b0; oe_n = 1'b0;
        idle(1);
        check("R9 ram_oe_n held in reset", {31'd0, ram_oe_n}, 32'd1);
        ce_n = 1'b1; oe_n = 1'b1;
        rst = 1'b0;
        idle(3);
        read_check("R9 cleared reg 0", 17'h0);
        read_check("R9 cleared reg 63", 17'h3F);

        // R6/R7: write-enable controlled, last value wins
        do_write(17'h05, 8'h11, 8'hA5, 1'b0);
        read_check("R6 R7 we-controlled write", 17'h05);
        // R6/R7: chip-enable controlled
        do_write(17'h3F, 8'h22, 8'h5A, 1'b1);
        read_check("R6 R7 ce-controlled write at 0x3F", 17'h3F);
        do_write(17'h00, 8'h33, 8'hC3, 1'b1);
        read_check("R2 R1 read of 0x00", 17'h00);

        // R8: writes above the window leave registers alone
        do_write(17'h45, 8'hFF, 8'hEE, 1'b0);
        read_check("R8 ext write kept reg 0x05", 17'h05);
        do_write(17'h40, 8'h01, 8'h02, 1'b1);
        read_check("R8 ext write kept reg 0x00", 17'h00);

        // R1/R4/R5: boundary reads outside the window
        read_check("R1 R5 read at 0x40", 17'h40);
        read_check("R1 R5 read at 0x1FFFF", 17'h1FFFF);

        // R4: live pass-through of oe_n above the window
        @(negedge clk);
        addr = 17'h1234; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
        #1 check("R4 ram_oe_n follows oe_n low", {31'd0, ram_oe_n}, 32'd0);
        oe_n = 1'b1;
        #1 check("R4 ram_oe_n follows oe_n high", {31'd0, ram_oe_n}, 32'd1);
        ce_n = 1'b1;
        idle(4);

        // R5: output enable high on an in-window address
        @(negedge clk);
        addr = 17'h05; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
        idle(5);
        check("R5 no drive with oe_n high", {31'd0, rd_drive}, 32'd0);
        check("R5 rd_data zero with oe_n high", {24'd0, rd_data}, 32'd0);
        // R5: enter read, then lift ce_n
        oe_n = 1'b0;
        idle(5);
        check("R2 drive during read", {31'd0, rd_drive}, 32'd1);
        ce_n = 1'b1;
        #1 check("R5 no drive with ce_n high", {31'd0, rd_drive}, 32'd0);
        ce_n = 1'b0;
        #1 we_n = 1'b0;
        #1 check("R5 no drive with we_n low", {31'd0, rd_drive}, 32'd0);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        idle(5);

        // Random mix
        for (int k = 0; k < 80; k++) begin
            logic [AW-1:0] a;
            int kind = $urandom_range(0, 3);
            a = ($urandom_range(0, 3) == 0) ? AW'($urandom_range(64, 131071))
                                            : AW'($urandom_range(0, 63));
            if (kind < 2) do_write(a, DW'($urandom), DW'($urandom), kind[0]);
            else          read_check("R2 R8 random read", a);
        end
        for (int i = 0; i < NWIN; i += 9) read_check("R2 sweep read", AW'(i));

        // R9: reset after traffic clears everything
        @(negedge clk); rst = 1'b1;
        idle(2);
        rst = 1'b0;
        for (int i = 0; i < NWIN; i++) model[i] = '0;
        idle(2);
        for (int i = 0; i < NWIN; i += 7) begin
            do_read(AW'(i), d, drv, ob);
            check("R9 cleared after traffic", {24'd0, d}, 32'd0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule